// File: doc/BRIEF.md
# GPIO Bank with Four-Way Peripheral Multiplexer

This block controls a bank of 32 general-purpose pins. For each pin it decides whether the pin belongs to the GPIO logic or to one of four on-chip peripheral functions, named A to D. It also drives the pad-side output value, output enable, pull-up and pull-down requests, and an open-drain option. It samples the pad level and synchronises it, so software can read that level back. Software reaches everything through a small register bus. Each control has three addresses. Writing ones to the set address turns bits on. Writing ones to the clear address turns bits off. The status address reads the current state. Only the bits written as one change.

Two plain read/write registers hold the peripheral choice as a two-bit code per pin. The pull-up and pull-down enables are mutually exclusive in hardware: setting one clears the other for the same pins. The synchronised pad level can be read for every pin, whoever owns it. The bus has no wait states. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are high. A read is combinational from the current state while `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset, every pin is GPIO-owned with output enable 0 and output data 0. Pull-up reads all ones, pull-down reads all zeros, open-drain is off, and both select registers are zero. So `pad_oe` is 0 and `pad_pu` is all ones.
- R2: Word addresses (`bus_addr`) are grouped by control, each group being set/clear/status: ownership 0/1/2, output enable 3/4/5, output data 6/7/8, pull-up 9/10/11, pull-down 12/13/14, open-drain 15/16/17. A write of mask M to a set address sets exactly the bits of M in that control, and the status address then returns the new value.
- R3: A write of mask M to a clear address clears exactly the bits of M in that control and leaves the other bits unchanged.
- R4: Setting pull-down bits clears the pull-up bits of the same pins, and setting pull-up bits clears the same pull-down bits. No pin ever has both `pad_pu` and `pad_pd` high.
- R5: A pin whose ownership bit is 0 takes its output value and output enable from the peripheral selected by {sel2[i], sel1[i]}: 00 is A, 01 is B, 10 is C, 11 is D. Select register 1 is at address 18 and select register 2 at address 19, both read/write. Peripheral k drives bits [k*32+i] of `periph_out` and `periph_oe`.
- R6: A GPIO-owned pin without open-drain drives `pad_out` from its output-data bit and `pad_oe` from its output-enable bit.
- R7: With open-drain on, a pin drives `pad_out` low with `pad_oe` high when its value is 0 and its enable is 1. It releases the pad (`pad_oe` low) when its value is 1.
- R8: Address 20 returns `pad_in` delayed by two clock edges, for every pin regardless of ownership.
- R9: Reads of set or clear addresses return zero. Writes to status addresses and to address 20 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Read data |
| periph_out | input | 128 | Output values of peripherals A..D, 32 bits each |
| periph_oe | input | 128 | Output enables of peripherals A..D |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pull-up request |
| pad_pd | output | 32 | Pull-down request |

## Verification
The bench uses partial masks so that untouched bits are seen to survive. A register that wrote the whole word, or inverted the mask, would change pins the mask did not name. It gives each of four pins a different select code and enables one peripheral at a time. A swapped select bit or a wrong peripheral index then shows up as the high level landing on the wrong pin. It checks the pull-up/pull-down exclusion in both directions, and the open-drain release when the output value goes high. It reads the pin level one edge and two edges after a change, so a missing or extra synchroniser stage shows up. It also checks that writes to status addresses leave the state alone.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NCTL = 6;
  localparam int C_OWN = 0;
  localparam int C_OE  = 1;
  localparam int C_DAT = 2;
  localparam int C_PU  = 3;
  localparam int C_PD  = 4;
  localparam int C_OD  = 5;
  localparam int NPERIPH = 4;
  localparam int A_SEL1  = 18;
  localparam int A_SEL2  = 19;
  localparam int A_LEVEL = 20;

  // reset polarity of each control: ownership and pull-up start at ones
  function automatic logic ctl_reset_one(int idx);
    return (idx == C_OWN) || (idx == C_PU);
  endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int   W       = 32,
  parameter logic RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  // clear wins over set for the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {W{RST_ONE}};
    else        q <= (q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0]         own,
  input  logic [NPIN-1:0]         oe,
  input  logic [NPIN-1:0]         dat,
  input  logic [NPIN-1:0]         od,
  input  logic [NPIN-1:0]         sel1,
  input  logic [NPIN-1:0]         sel2,
  input  logic [NPERIPH*NPIN-1:0] periph_out,
  input  logic [NPERIPH*NPIN-1:0] periph_oe,
  output logic [NPIN-1:0]         pad_out,
  output logic [NPIN-1:0]         pad_oe
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [1:0] code;
    logic       drv_val, drv_en;
    assign code = {sel2[p], sel1[p]};
    always_comb begin
      if (own[p]) begin
        drv_val = dat[p];
        drv_en  = oe[p];
      end else begin
        drv_val = periph_out[int'(code)*NPIN + p];
        drv_en  = periph_oe[int'(code)*NPIN + p];
      end
      if (od[p]) begin
        pad_out[p] = 1'b0;
        pad_oe[p]  = drv_en & ~drv_val;
      end else begin
        pad_out[p] = drv_val;
        pad_oe[p]  = drv_en;
      end
    end
  end
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [NPIN-1:0]         bus_wdata,
  output logic [NPIN-1:0]         bus_rdata,
  input  logic [NPERIPH*NPIN-1:0] periph_out,
  input  logic [NPERIPH*NPIN-1:0] periph_oe,
  input  logic [NPIN-1:0]         pad_in,
  output logic [NPIN-1:0]         pad_out,
  output logic [NPIN-1:0]         pad_oe,
  output logic [NPIN-1:0]         pad_pu,
  output logic [NPIN-1:0]         pad_pd
);
  logic            wr_hit;
  logic [NPIN-1:0] raw_set [NCTL];
  logic [NPIN-1:0] raw_clr [NCTL];
  logic [NPIN-1:0] set_m   [NCTL];
  logic [NPIN-1:0] clr_m   [NCTL];
  logic [NPIN-1:0] ctl_q   [NCTL];
  logic [NPIN-1:0] sel1_q, sel2_q, level_q;
  logic [NPIN-1:0] own_q, oe_q, dat_q, pu_q, pd_q, od_q;

  assign wr_hit = bus_sel & bus_wr;

  always_comb begin
    for (int i = 0; i < NCTL; i++) begin
      raw_set[i] = (wr_hit && bus_addr == AW'(3*i))     ? bus_wdata : '0;
      raw_clr[i] = (wr_hit && bus_addr == AW'(3*i + 1)) ? bus_wdata : '0;
    end
    for (int i = 0; i < NCTL; i++) begin
      set_m[i] = raw_set[i];
      clr_m[i] = raw_clr[i];
    end
    // pull enables exclude each other
    clr_m[C_PU] = raw_clr[C_PU] | raw_set[C_PD];
    clr_m[C_PD] = raw_clr[C_PD] | raw_set[C_PU];
  end

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    gpio_setclr_reg #(.W(NPIN), .RST_ONE(ctl_reset_one(g))) u_reg (
      .clk(clk), .rst_n(rst_n),
      .set_mask(set_m[g]), .clr_mask(clr_m[g]), .q(ctl_q[g])
    );
  end

  assign own_q = ctl_q[C_OWN];
  assign oe_q  = ctl_q[C_OE];
  assign dat_q = ctl_q[C_DAT];
  assign pu_q  = ctl_q[C_PU];
  assign pd_q  = ctl_q[C_PD];
  assign od_q  = ctl_q[C_OD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel1_q <= '0;
      sel2_q <= '0;
    end else if (wr_hit) begin
      if (bus_addr == AW'(A_SEL1)) sel1_q <= bus_wdata;
      if (bus_addr == AW'(A_SEL2)) sel2_q <= bus_wdata;
    end
  end

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(level_q)
  );

  gpio_pad_mux #(.NPIN(NPIN)) u_mux (
    .own(own_q), .oe(oe_q), .dat(dat_q), .od(od_q),
    .sel1(sel1_q), .sel2(sel2_q),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pad_pu = pu_q;
  assign pad_pd = pd_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      for (int i = 0; i < NCTL; i++)
        if (bus_addr == AW'(3*i + 2)) bus_rdata = ctl_q[i];
      if (bus_addr == AW'(A_SEL1))  bus_rdata = sel1_q;
      if (bus_addr == AW'(A_SEL2))  bus_rdata = sel2_q;
      if (bus_addr == AW'(A_LEVEL)) bus_rdata = level_q;
    end
  end
endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pad_in,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_pu,
  input logic [NPIN-1:0] pad_pd,
  input logic [NPIN-1:0] own_q,
  input logic [NPIN-1:0] oe_q,
  input logic [NPIN-1:0] dat_q,
  input logic [NPIN-1:0] od_q,
  input logic [NPIN-1:0] level_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_oe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(3)) |=> ((oe_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_dat_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(7)) |=> ((dat_q & $past(bus_wdata)) == '0));

  assert_pull_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == '0));

  assert_gpio_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((own_q & ~od_q) & ((pad_oe ^ oe_q) | (pad_out ^ dat_q))) == '0));

  assert_open_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((od_q & pad_oe & pad_out) == '0));

  assert_level_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (level_q == $past(pad_in, 2)));

  assert_status_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(5)) |=> $stable(oe_q));
endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
  .own_q(own_q), .oe_q(oe_q), .dat_q(dat_q), .od_q(od_q), .level_q(level_q)
);

// File: tb/gpio_mux_bank_tb.sv
`timescale 1ns/1ps
module gpio_mux_bank_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] periph_out = '0;
  logic [127:0] periph_oe = '1;
  logic [31:0]  pad_in = '0;
  logic [31:0]  pad_out, pad_oe, pad_pu, pad_pd;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_mux_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_out(periph_out), .periph_oe(periph_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'd2, v);  chk("R1 ownership", v, 32'hFFFF_FFFF);
    rd(5'd5, v);  chk("R1 output enable", v, 32'h0);
    rd(5'd11, v); chk("R1 pull-up", v, 32'hFFFF_FFFF);
    rd(5'd14, v); chk("R1 pull-down", v, 32'h0);
    rd(5'd18, v); chk("R1 select 1", v, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_pu", pad_pu, 32'hFFFF_FFFF);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(5'd3, 32'h0000_00F0);
    rd(5'd5, v); chk("R2 oe set", v, 32'h0000_00F0);
    wr(5'd4, 32'h0000_0030);
    rd(5'd5, v); chk("R3 oe clear", v, 32'h0000_00C0);
    wr(5'd6, 32'h0000_FFFF);
    wr(5'd7, 32'h0000_0F00);
    rd(5'd8, v); chk("R3 data clear", v, 32'h0000_F0FF);
    chk("R6 pad_oe", pad_oe, 32'h0000_00C0);
    chk("R6 pad_out", pad_out, 32'h0000_F0FF);
  endtask

  task automatic t_mux;
    logic [31:0] v;
    wr(5'd1, 32'hF000_0000);
    wr(5'd18, 32'hA000_0000);
    wr(5'd19, 32'hC000_0000);
    rd(5'd19, v); chk("R5 select 2 readback", v, 32'hC000_0000);
    for (int k = 0; k < 4; k++) begin
      periph_out = '0;
      periph_out[k*32 +: 32] = 32'hFFFF_FFFF;
      #1;
      chk($sformatf("R5 peripheral %0d routing", k), {28'h0, pad_out[31:28]}, 32'h1 << k);
    end
    periph_oe = '0;
    periph_oe[2*32 +: 32] = 32'hFFFF_FFFF;
    #1 chk("R5 peripheral enable", {28'h0, pad_oe[31:28]}, 32'h4);
    chk("R5 owned pins untouched", {4'h0, pad_oe[27:0]}, 32'h0000_00C0);
    periph_oe = '1;
  endtask

  task automatic t_opendrain;
    wr(5'd15, 32'h0000_0080);
    chk("R7 release on high", {31'h0, pad_oe[7]}, 32'h0);
    wr(5'd7, 32'h0000_0080);
    chk("R7 drive low oe", {31'h0, pad_oe[7]}, 32'h1);
    chk("R7 drive low value", {31'h0, pad_out[7]}, 32'h0);
  endtask

  task automatic t_pull;
    logic [31:0] v;
    wr(5'd12, 32'h0000_000F);
    rd(5'd11, v); chk("R4 pull-down clears pull-up", v, 32'hFFFF_FFF0);
    rd(5'd14, v); chk("R4 pull-down set", v, 32'h0000_000F);
    wr(5'd9, 32'h0000_0003);
    rd(5'd14, v); chk("R4 pull-up clears pull-down", v, 32'h0000_000C);
    chk("R4 pad_pu", pad_pu, 32'hFFFF_FFF3);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd(5'd20, v); chk("R8 level after one edge", v, 32'h0);
    @(negedge clk);
    rd(5'd20, v); chk("R8 level after two edges", v, 32'h1234_5678);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wr(5'd5, 32'hFFFF_FFFF);
    rd(5'd5, v); chk("R9 status write ignored", v, 32'h0000_00C0);
    wr(5'd20, 32'h0);
    rd(5'd20, v); chk("R9 level write ignored", v, 32'h1234_5678);
    rd(5'd0, v); chk("R9 set address reads zero", v, 32'h0);
    rd(5'd10, v); chk("R9 clear address reads zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_setclr;
    t_mux;
    t_opendrain;
    t_pull;
    t_level;
    t_ignored;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule